// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block produces the word address used by each beat of a burst transfer on a memory bus. A start strobe captures a start address together with a three-bit length code and a wrap-enable bit. Each advance strobe then moves the address to the next word. The configuration is sampled only when the start strobe is taken, so it cannot change in the middle of a burst.

Fixed-length bursts are 4, 8, 16 or 32 words long. With wrap enabled, the address cycles inside the aligned window whose size equals the burst length. With wrap disabled, the address counts upward in sequence. A continuous burst keeps running until the next start strobe and is always sequential. A last-beat flag marks the final word of a fixed-length burst. A row-end flag marks the last word of a 128-word row whenever sequential addressing is in use, so that the bus can insert wait states before the next row. Driving the bus pins and counting latency are handled outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: A start strobe loads the start address, the length code and the wrap bit. From the next cycle the address output equals the start address and the burst is active. When start and advance arrive in the same cycle, start takes priority.
- R2: During sequential addressing, each accepted advance adds one to the full word address.
- R3: With wrap enabled and a fixed length L, an advance increments only the low log2(L) address bits, modulo L. All higher bits hold.
- R4: The length code values are 3'b001 = 4 words, 3'b010 = 8, 3'b011 = 16 and 3'b100 = 32. In a fixed-length burst, the last-beat flag is high exactly while the L-th word (beat index L-1) is presented.
- R5: The codes 3'b111, 3'b000, 3'b101 and 3'b110 select a continuous burst. A continuous burst never raises the last-beat flag, ignores the wrap bit and counts sequentially.
- R6: During sequential addressing (wrap bit 0, or any continuous burst), the row-end flag is high while the active address has its low seven bits all ones, meaning the next word starts a new 128-word row.
- R7: During a fixed-length burst with wrap enabled, the row-end flag stays low, even when the window contains the last word of a row.
- R8: The advance that consumes the last beat ends the burst. After that the address holds, both flags stay low, and further advance strobes have no effect until the next start.
- R9: A start strobe during an active burst abandons that burst and begins the new one from its own start address at beat zero.
- R10: After reset the address is zero, no burst is active, and both flags are low.
- R11: In a cycle with no advance and no start, the address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new burst this cycle |
| start_addr | input | AW | Word address of the first beat |
| len_code | input | 3 | Burst length code, sampled on start |
| wrap_en | input | 1 | 1 selects wrapping within the burst length, sampled on start |
| advance | input | 1 | Move to the next beat |
| addr | output | AW | Word address of the current beat |
| last_beat | output | 1 | Current beat is the final word of a fixed-length burst |
| row_end | output | 1 | Current word is the last of its row during sequential addressing |

## Verification
Every output comes straight from registers. An effect of start or advance therefore shows up one rising edge later, and the two flags are decoded from the same registered state in that same cycle. The bench changes inputs one nanosecond after a rising edge and samples on the falling edge that follows. Each sample therefore shows the state left by the edge just before it, and the scoreboard holds the expected value for that beat only. The post-burst and stall checks rely on this same one-edge delay: they sample the state that follows an ignored advance, or a held cycle.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW    = 22,
  parameter int ROW_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [2:0]    len_code,
  input  logic          wrap_en,
  input  logic          advance,
  output logic [AW-1:0] addr,
  output logic          last_beat,
  output logic          row_end
);
  localparam int MAX_LG = 5;
  localparam int CNT_W  = MAX_LG;

  logic [AW-1:0]    addr_q, mask, nxt;
  logic [2:0]       code_q, lg;
  logic             wrap_q, active, cont, wrap_eff, fin;
  logic [CNT_W-1:0] beat;

  always_comb begin
    case (code_q)
      3'b001:  lg = 3'd2;
      3'b010:  lg = 3'd3;
      3'b011:  lg = 3'd4;
      3'b100:  lg = 3'd5;
      default: lg = 3'd0;
    endcase
  end

  assign cont     = (lg == 3'd0);
  assign mask     = (AW'(1) << lg) - AW'(1);
  assign wrap_eff = wrap_q & ~cont;
  assign nxt      = wrap_eff ? ((addr_q & ~mask) | ((addr_q + AW'(1)) & mask))
                             : addr_q + AW'(1);
  assign fin      = ~cont & (beat == mask[CNT_W-1:0]);

  assign addr      = addr_q;
  assign last_beat = active & fin;
  assign row_end   = active & ~wrap_eff & (&addr_q[ROW_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      code_q <= 3'b111;
      wrap_q <= 1'b0;
      active <= 1'b0;
      beat   <= '0;
    end else if (start) begin
      addr_q <= start_addr;
      code_q <= len_code;
      wrap_q <= wrap_en;
      active <= 1'b1;
      beat   <= '0;
    end else if (active && advance) begin
      if (fin) begin
        active <= 1'b0;
      end else begin
        addr_q <= nxt;
        if (!cont) beat <= beat + CNT_W'(1);
      end
    end
  end
endmodule

module burst_addr_gen_chk #(
  parameter int AW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] start_addr,
  input logic          advance,
  input logic [AW-1:0] addr,
  input logic          last_beat,
  input logic          row_end,
  input logic          active,
  input logic          cont,
  input logic          wrap_eff
);
  p_start_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (addr == $past(start_addr)) && active);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && advance && active && !wrap_eff && !last_beat) |=> addr == $past(addr) + AW'(1));

  p_wrap_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && advance && active && wrap_eff) |=> (addr >> 5) == ($past(addr) >> 5));

  p_last_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> !cont);

  p_row_nowrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |-> !wrap_eff);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!last_beat && !row_end));

  p_end_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && advance && last_beat) |=> !active && $stable(addr));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !advance) |=> $stable(addr));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
  .advance(advance), .addr(addr), .last_beat(last_beat), .row_end(row_end),
  .active(active), .cont(cont), .wrap_eff(wrap_eff)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 22;

  typedef struct {
    logic [AW-1:0] a;
    logic          last;
    logic          row;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [2:0]    len_code = 3'b111;
  logic          wrap_en = 1'b0;
  logic          advance = 1'b0;
  logic [AW-1:0] addr;
  logic          last_beat, row_end;

  logic  chk_en = 1'b0;
  exp_t  q[$];
  int    checks = 0;
  int    errors = 0;
  bit    reported = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .len_code(len_code), .wrap_en(wrap_en), .advance(advance),
    .addr(addr), .last_beat(last_beat), .row_end(row_end)
  );

  task automatic compare(exp_t e);
    checks++;
    if (addr !== e.a || last_beat !== e.last || row_end !== e.row) begin
      errors++;
      $display("FAIL %s: addr=%h last=%b row=%b expected addr=%h last=%b row=%b",
               e.tag, addr, last_beat, row_end, e.a, e.last, e.row);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: no expected item, addr=%h expected none", addr);
      end else begin
        compare(q.pop_front());
      end
    end
  end

  function automatic int lg_of(logic [2:0] c);
    case (c)
      3'b001: return 2;
      3'b010: return 3;
      3'b011: return 4;
      3'b100: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic exp_t model(logic [AW-1:0] s, logic [2:0] c, logic w, int i, string tag);
    exp_t e;
    int lg = lg_of(c);
    logic cnt = (lg == 0);
    logic [AW-1:0] m = (AW'(1) << lg) - AW'(1);
    logic weff = w && !cnt;
    e.a    = weff ? ((s & ~m) | ((s + AW'(i)) & m)) : s + AW'(i);
    e.last = !cnt && (i == (1 << lg) - 1);
    e.row  = !weff && (e.a[6:0] == 7'h7f);
    e.tag  = tag;
    return e;
  endfunction

  task automatic burst(logic [AW-1:0] s, logic [2:0] c, logic w, int n, int stall, string tag);
    exp_t e, hold;
    int lg = lg_of(c);
    start <= 1'b1; start_addr <= s; len_code <= c; wrap_en <= w; advance <= 1'b0;
    @(posedge clk); #1;
    start <= 1'b0;
    for (int k = 0; k < stall; k++) begin
      e = model(s, c, w, 0, "R11 hold");
      q.push_back(e); chk_en <= 1'b1;
      @(posedge clk); #1;
    end
    for (int i = 0; i < n; i++) begin
      e = model(s, c, w, i, tag);
      q.push_back(e); chk_en <= 1'b1; advance <= 1'b1;
      @(posedge clk); #1;
    end
    if (lg != 0 && n == (1 << lg)) begin
      hold = model(s, c, w, n - 1, "R8 idle after last");
      hold.last = 1'b0; hold.row = 1'b0;
      for (int k = 0; k < 2; k++) begin
        q.push_back(hold);
        @(posedge clk); #1;
      end
    end
    chk_en <= 1'b0; advance <= 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end

  initial begin
    exp_t r;
    @(negedge clk);
    r.a = '0; r.last = 1'b0; r.row = 1'b0; r.tag = "R10 reset";
    compare(r);
    @(posedge clk); #1;
    rst_n <= 1'b1;
    @(posedge clk); #1;
    // Advance while idle after reset changes nothing (R10)
    advance <= 1'b1;
    @(posedge clk); #1;
    advance <= 1'b0;
    @(negedge clk);
    compare(r);
    @(posedge clk); #1;

    burst(22'h03F7C, 3'b111, 1'b0, 8, 0, "R2 R6 continuous sequential");
    burst(22'h0017E, 3'b111, 1'b1, 4, 0, "R5 R6 continuous ignores wrap");
    burst(22'h00200, 3'b000, 1'b0, 6, 0, "R5 code 000 continuous");
    burst(22'h0037D, 3'b101, 1'b1, 5, 0, "R5 code 101 continuous");
    burst(22'h00410, 3'b110, 1'b0, 5, 0, "R5 code 110 continuous");
    burst(22'h00106, 3'b001, 1'b1, 4, 2, "R3 R4 wrap 4");
    burst(22'h02A5B, 3'b010, 1'b1, 8, 0, "R3 R4 wrap 8");
    burst(22'h0007C, 3'b011, 1'b1, 16, 0, "R3 R7 wrap 16 over row end");
    burst(22'h001F1, 3'b100, 1'b1, 32, 0, "R3 R4 R7 wrap 32");
    burst(22'h0017E, 3'b001, 1'b0, 4, 0, "R2 R4 R6 sequential 4 across row");
    burst(22'h00010, 3'b011, 1'b0, 16, 0, "R2 R4 sequential 16");
    // R9: abandon an 8-beat burst after 3 beats, restart elsewhere
    burst(22'h00040, 3'b010, 1'b1, 3, 0, "R1 first part");
    burst(22'h3FFFE, 3'b001, 1'b0, 4, 1, "R9 R1 restart mid-burst");
    // R1: start and advance together, start wins
    start <= 1'b1; advance <= 1'b1; start_addr <= 22'h01234; len_code <= 3'b010; wrap_en <= 1'b0;
    @(posedge clk); #1;
    start <= 1'b0; advance <= 1'b0;
    @(negedge clk);
    r.a = 22'h01234; r.last = 1'b0; r.row = 1'b0; r.tag = "R1 start over advance";
    compare(r);
    @(posedge clk); #1;

    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    report();
  end
endmodule